// File: doc/BRIEF.md
# Per-Word Sticky Lock Register Bank

This block holds three lock planes for the words of a fuse array: a reload lock, a shadow-write lock and a programming lock. Each plane has one bit per word. Software sets lock bits over a simple register bus by writing ones. Once set, a bit stays set until the block is reset.

A global lock register adds three feature locks:
- an upper-words lock, which the block only exports;
- a debug-configuration lock, which freezes the debug-enable register;
- a programming lock, which refuses every program operation.

The bank also exposes a read-only view of an externally supplied permanent-lock vector, using the same banked layout as the planes.

A fuse controller uses the gating side. It presents a word index and, optionally, a one-cycle request strobe for a reload, a shadow write or a program. The block answers combinationally with an allow signal for each operation. A refused strobe raises the matching violation flag for one cycle. The controller turns a refused operation into a no-op.

Top module: `fuse_lock_bank`

## Requirements
- R1: After reset, every lock bit, the global lock register and the debug-enable register read zero, and every allow output is 1 for each word index below NUM_WORDS.
- R2: A plane write sets each lock bit whose mask bit is 1. Mask bits of 0 change nothing, and no write ever clears a set bit. Only reset clears a bit.
- R3: The planes are banked. Bank b sits at plane base + 4*b, and data bit j of bank b is word 32*b+j. The plane bases are 0x064 for programming, 0x07C for shadow write and 0x094 for reload. Each plane has three bank slots, and reads return 1 for each locked word.
- R4: The permanent-lock view at 0x04C returns `perm_lock` in the same banked layout. Writes to it have no effect.
- R5: The global lock register sits at 0x010. Bit 0 is the upper lock, bit 2 the debug lock and bit 4 the programming lock. These bits are set-only, and all other bits read 0. `upper_lock` follows bit 0.
- R6: While the global programming lock is set, `allow_prog` is 0 for every word.
- R7: The debug-enable register at 0x014 takes writes while the debug lock is clear, and ignores them once it is set. A read always returns the stored value, which also drives `dbg_enable`.
- R8: `allow_reload`, `allow_swrite` and `allow_prog` are combinational. Each is 1 exactly when the lock bit of `req_word` in its plane is clear (for programming, also the global lock must be clear).
- R9: A request strobe whose allow is 0 raises the matching `viol_*` output in the following cycle, for one cycle. Otherwise `viol_*` stays 0.
- R10: Word indices at or above NUM_WORDS read as 0 in every plane. Writes to them are ignored, and requests for them are refused.
- R11: Reads of any address outside the mapped registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data / set mask |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| perm_lock | input | NUM_WORDS | Permanent-lock status per word |
| req_word | input | IDX_W | Word index of the pending operation |
| req_reload | input | 1 | Reload request strobe |
| req_swrite | input | 1 | Shadow-write request strobe |
| req_prog | input | 1 | Program request strobe |
| allow_reload | output | 1 | Reload permitted for req_word |
| allow_swrite | output | 1 | Shadow write permitted for req_word |
| allow_prog | output | 1 | Program permitted for req_word |
| viol_reload | output | 1 | Refused reload strobe, one-cycle pulse |
| viol_swrite | output | 1 | Refused shadow-write strobe, one-cycle pulse |
| viol_prog | output | 1 | Refused program strobe, one-cycle pulse |
| upper_lock | output | 1 | Global upper-words lock |
| dbg_enable | output | 32 | Stored debug-enable value |

## Verification
The bench builds the block with NUM_WORDS = 40, which gives IDX_W = 6. Bank 0 is then full, bank 1 holds only 8 valid words, and bank 2 lies wholly beyond the range. With these values every word index from 0 to 63 can be swept, so the in-range and out-of-range gating is covered word by word. Full-ones writes to the partial and empty banks show that the bits past NUM_WORDS stay zero.

// File: rtl/lockbank_pkg.sv
// Shared address map, plane identifiers and the bank decode helper.
package lockbank_pkg;
    localparam logic [11:0] OFF_GLOCK  = 12'h010;
    localparam logic [11:0] OFF_DBG    = 12'h014;
    localparam logic [11:0] OFF_PERM   = 12'h04C;
    localparam logic [11:0] OFF_PROG   = 12'h064;
    localparam logic [11:0] OFF_SWRITE = 12'h07C;
    localparam logic [11:0] OFF_RELOAD = 12'h094;
    localparam int          BANK_W     = 32;
    localparam int          BANK_SLOTS = 3;
    localparam int          NPLANES    = 3;

    typedef enum logic [1:0] {PL_PROG = 2'd0, PL_SWRITE = 2'd1, PL_RELOAD = 2'd2} plane_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] bank;
    } bank_sel_t;

    // Base offset of a lock plane.
    function automatic logic [11:0] plane_base(input int p);
        case (p)
            0:       plane_base = OFF_PROG;
            1:       plane_base = OFF_SWRITE;
            default: plane_base = OFF_RELOAD;
        endcase
    endfunction

    // Decode an address against a banked region of BANK_SLOTS word registers.
    function automatic bank_sel_t bank_decode(input logic [11:0] addr, input logic [11:0] base);
        logic [11:0] d;
        d = addr - base;
        bank_decode.hit  = (addr >= base) && (d < 12'(4 * BANK_SLOTS)) && (addr[1:0] == 2'b00);
        bank_decode.bank = d[3:2];
    endfunction
endpackage

// File: rtl/lock_bank_view.sv
// Banked read view of a per-word vector.
// Assumes NUM_WORDS <= BANK_W*BANK_SLOTS. Bits at or past NUM_WORDS read as 0.
module lock_bank_view #(
    parameter int NUM_WORDS = 96
) (
    input  logic [NUM_WORDS-1:0] vec,
    input  logic [1:0]           sel_bank,
    output logic [31:0]          rd_data
);
    import lockbank_pkg::*;
    localparam int NB = (NUM_WORDS + BANK_W - 1) / BANK_W;

    logic [NB*BANK_W-1:0] padded;

    // Zero-pad the vector up to whole banks.
    always_comb begin
        padded                 = '0;
        padded[NUM_WORDS-1:0]  = vec;
    end

    // Select the addressed bank; banks beyond the word range read zero.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (sel_bank == 2'(b)) rd_data = padded[b*BANK_W +: BANK_W];
        end
    end
endmodule

// File: rtl/lock_plane.sv
// One sticky lock plane: one write-one-to-set bit per word, a banked readback
// and a lock lookup for a requested word. Indices >= NUM_WORDS are reported locked.
module lock_plane #(
    parameter int NUM_WORDS = 96,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel_bank,
    input  logic [31:0]      wr_mask,
    output logic [31:0]      rd_data,
    input  logic [IDX_W-1:0] chk_word,
    output logic             chk_locked
);
    import lockbank_pkg::*;

    logic [NUM_WORDS-1:0] bits;
    logic [NUM_WORDS-1:0] set_vec;
    logic [NUM_WORDS-1:0] prev_bits;

    // Map the bank write mask onto word positions.
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            set_vec[i] = wr_en && (sel_bank == 2'(i / BANK_W)) && wr_mask[i % BANK_W];
        end
    end

    // Lock bits accumulate set requests; only reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= bits | set_vec;
    end

    // Lock lookup for the requested word; out-of-range words count as locked.
    always_comb begin
        chk_locked = 1'b1;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (chk_word == IDX_W'(i)) chk_locked = bits[i];
        end
    end

    lock_bank_view #(.NUM_WORDS(NUM_WORDS)) u_view (
        .vec      (bits),
        .sel_bank (sel_bank),
        .rd_data  (rd_data)
    );

    // Previous state, kept for the stickiness check.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_bits <= '0;
        else        prev_bits <= bits;
    end

    a_r2_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bits & prev_bits) == prev_bits);
endmodule

// File: rtl/lock_global.sv
// Global feature locks (upper, debug, programming) and the debug-enable register.
// The feature locks are set-only. The debug register is frozen by the debug lock.
module lock_global (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_glock,
    input  logic        wr_dbg,
    input  logic [31:0] wdata,
    output logic [31:0] glock_word,
    output logic [31:0] dbg_val,
    output logic        glk_upper,
    output logic        glk_dbg,
    output logic        glk_prog
);
    // Feature lock bits: set by writing ones at bits 0, 2 and 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glk_upper <= 1'b0;
            glk_dbg   <= 1'b0;
            glk_prog  <= 1'b0;
        end else if (wr_glock) begin
            glk_upper <= glk_upper | wdata[0];
            glk_dbg   <= glk_dbg   | wdata[2];
            glk_prog  <= glk_prog  | wdata[4];
        end
    end

    // Debug-enable register, writable only while the debug lock is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dbg_val <= '0;
        else if (wr_dbg && !glk_dbg) dbg_val <= wdata;
    end

    // Readback image of the global lock register.
    assign glock_word = {27'b0, glk_prog, 1'b0, glk_dbg, 1'b0, glk_upper};

    a_r7_dbg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        glk_dbg |=> $stable(dbg_val));
    a_r5_prog_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        glk_prog |=> glk_prog);
endmodule

// File: rtl/fuse_lock_bank.sv
// Top of the lock bank. It decodes the register bus, holds three lock planes,
// the global locks and the permanent-lock view, and gates per-word operations.
// Assumes NUM_WORDS <= 96 (three 32-bit bank slots per plane).
module fuse_lock_bank #(
    parameter int NUM_WORDS = 96,
    parameter int IDX_W     = $clog2(NUM_WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_WORDS-1:0] perm_lock,
    input  logic [IDX_W-1:0]     req_word,
    input  logic                 req_reload,
    input  logic                 req_swrite,
    input  logic                 req_prog,
    output logic                 allow_reload,
    output logic                 allow_swrite,
    output logic                 allow_prog,
    output logic                 viol_reload,
    output logic                 viol_swrite,
    output logic                 viol_prog,
    output logic                 upper_lock,
    output logic [31:0]          dbg_enable
);
    import lockbank_pkg::*;

    logic [31:0]        plane_rd  [NPLANES];
    logic [NPLANES-1:0] plane_hit;
    logic [NPLANES-1:0] plane_locked;
    logic [31:0]        glock_word;
    logic [31:0]        perm_rd;
    logic               glk_upper, glk_dbg, glk_prog;
    bank_sel_t          perm_sel;

    // One lock plane per operation kind, each at its own base offset.
    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        bank_sel_t sel;
        assign sel          = bank_decode(bus_addr, plane_base(p));
        assign plane_hit[p] = sel.hit;
        lock_plane #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_plane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bus_wr && sel.hit),
            .sel_bank   (sel.bank),
            .wr_mask    (bus_wdata),
            .rd_data    (plane_rd[p]),
            .chk_word   (req_word),
            .chk_locked (plane_locked[p])
        );
    end

    lock_global u_global (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_glock   (bus_wr && bus_addr == OFF_GLOCK),
        .wr_dbg     (bus_wr && bus_addr == OFF_DBG),
        .wdata      (bus_wdata),
        .glock_word (glock_word),
        .dbg_val    (dbg_enable),
        .glk_upper  (glk_upper),
        .glk_dbg    (glk_dbg),
        .glk_prog   (glk_prog)
    );

    // Read-only permanent-lock status in the banked layout.
    assign perm_sel = bank_decode(bus_addr, OFF_PERM);
    lock_bank_view #(.NUM_WORDS(NUM_WORDS)) u_perm (
        .vec      (perm_lock),
        .sel_bank (perm_sel.bank),
        .rd_data  (perm_rd)
    );

    // Read mux: mapped registers only; everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_GLOCK)   bus_rdata = glock_word;
        else if (bus_addr == OFF_DBG) bus_rdata = dbg_enable;
        else if (perm_sel.hit)        bus_rdata = perm_rd;
        else begin
            for (int p = 0; p < NPLANES; p++) begin
                if (plane_hit[p]) bus_rdata = plane_rd[p];
            end
        end
    end

    // Combinational gating for the requested word.
    assign allow_prog   = !plane_locked[PL_PROG] && !glk_prog;
    assign allow_swrite = !plane_locked[PL_SWRITE];
    assign allow_reload = !plane_locked[PL_RELOAD];
    assign upper_lock   = glk_upper;

    // One-cycle violation flags for refused request strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_reload <= 1'b0;
            viol_swrite <= 1'b0;
            viol_prog   <= 1'b0;
        end else begin
            viol_reload <= req_reload && !allow_reload;
            viol_swrite <= req_swrite && !allow_swrite;
            viol_prog   <= req_prog   && !allow_prog;
        end
    end

    a_r6_glock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prog && glk_prog) |=> viol_prog);
    a_r9_no_spurious_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !req_reload |=> !viol_reload);
    a_r9_no_spurious_swrite: assert property (@(posedge clk) disable iff (!rst_n)
        !req_swrite |=> !viol_swrite);
    a_r10_range_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_word) >= NUM_WORDS) |-> (!allow_reload && !allow_swrite && !allow_prog));
endmodule

// File: tb/tb_fuse_lock_bank.sv
module tb_fuse_lock_bank;
    localparam int NW = 40;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NW-1:0] perm_lock = '0;
    logic [IW-1:0] req_word = '0;
    logic          req_reload = 1'b0, req_swrite = 1'b0, req_prog = 1'b0;
    logic          allow_reload, allow_swrite, allow_prog;
    logic          viol_reload, viol_swrite, viol_prog;
    logic          upper_lock;
    logic [31:0]   dbg_enable;

    int errors = 0;
    int checks = 0;
    logic [NW-1:0] mdl [3];
    logic          done = 1'b0;

    always #5 clk = ~clk;

    fuse_lock_bank #(.NUM_WORDS(NW), .IDX_W(IW)) dut (.*);

    function automatic logic [11:0] base_of(input int p);
        return (p == 0) ? 12'h064 : (p == 1) ? 12'h07C : 12'h094;
    endfunction

    function automatic logic [31:0] bank_of(input logic [NW-1:0] v, input int b);
        logic [95:0] pad;
        pad = {56'b0, v};
        return pad[b*32 +: 32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic allow_of(input int p);
        return (p == 0) ? allow_prog : (p == 1) ? allow_swrite : allow_reload;
    endfunction

    task automatic check_planes(input string req);
        logic [31:0] d;
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 3; b++) begin
                bus_read(base_of(p) + 12'(4*b), d);
                check(req, d, bank_of(mdl[p], b));
            end
    endtask

    task automatic check_allow(input string req, input logic gprog);
        for (int w = 0; w < 64; w++) begin
            req_word = IW'(w);
            #1;
            for (int p = 0; p < 3; p++) begin
                logic e;
                e = (w < NW) ? !mdl[p][w] : 1'b0;
                if (p == 0 && gprog) e = 1'b0;
                check(req, {31'b0, allow_of(p)}, {31'b0, e});
            end
        end
    endtask

    task automatic pulse(input int p, input int w, input logic exp);
        @(negedge clk);
        req_word = IW'(w);
        if (p == 0) req_prog = 1'b1; else if (p == 1) req_swrite = 1'b1; else req_reload = 1'b1;
        @(negedge clk);
        req_prog = 1'b0; req_swrite = 1'b0; req_reload = 1'b0;
        check("R9 viol pulse", {29'b0, viol_prog, viol_swrite, viol_reload}, {29'b0, 3'(exp) << (2-p)});
        @(negedge clk);
        check("R9 viol clears", {29'b0, viol_prog, viol_swrite, viol_reload}, 32'b0);
    endtask

    initial begin
        logic [31:0] d;
        for (int p = 0; p < 3; p++) mdl[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_planes("R1 reset planes");
        bus_read(12'h010, d); check("R1 reset glock", d, 32'h0);
        bus_read(12'h014, d); check("R1 reset dbg", d, 32'h0);
        check_allow("R1 reset allow (R10 above range)", 1'b0);
        // R4 permanent view
        perm_lock = 40'hA5_1234_5678;
        for (int b = 0; b < 3; b++) begin
            bus_read(12'h04C + 12'(4*b), d); check("R4 perm view", d, bank_of(perm_lock, b));
        end
        bus_write(12'h04C, 32'hFFFF_FFFF);
        bus_write(12'h050, 32'hFFFF_FFFF);
        check_planes("R4 perm write no effect");
        bus_read(12'h04C, d); check("R4 perm after write", d, 32'h1234_5678);
        // R7 debug register writable while unlocked
        bus_write(12'h014, 32'h0000_1234);
        bus_read(12'h014, d); check("R7 dbg write", d, 32'h0000_1234);
        check("R7 dbg port", dbg_enable, 32'h0000_1234);
        // R9 unlocked word: no violation
        for (int p = 0; p < 3; p++) pulse(p, 5, 1'b0);
        // R2/R3 sweep: set a scattered pattern per plane, then write zeros
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < 64; w++) begin
                if ((w * 7 + p) % 5 == 0) begin
                    bus_write(base_of(p) + 12'(4 * (w / 32)), 32'(1) << (w % 32));
                    if (w < NW) mdl[p][w] = 1'b1;
                end
            end
            bus_write(base_of(p), 32'h0);
            bus_write(base_of(p) + 12'd4, 32'h0);
        end
        check_planes("R2 R3 set-only banked readback");
        check_allow("R8 gating per word", 1'b0);
        // R10 bank beyond range ignores writes
        bus_write(base_of(1) + 12'd8, 32'hFFFF_FFFF);
        bus_read(base_of(1) + 12'd8, d); check("R10 empty bank", d, 32'h0);
        // R9 locked word: violation pulse
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < NW; w++)
                if (mdl[p][w]) begin pulse(p, w, 1'b1); break; end
        end
        pulse(1, 50, 1'b1);
        // R5/R7 debug lock
        bus_write(12'h010, 32'h0000_0004);
        bus_read(12'h010, d); check("R5 glock dbg bit", d, 32'h4);
        bus_write(12'h014, 32'hDEAD_BEEF);
        bus_read(12'h014, d); check("R7 dbg write ignored", d, 32'h0000_1234);
        check("R5 upper clear", {31'b0, upper_lock}, 32'h0);
        // R6 programming lock
        bus_write(12'h010, 32'h0000_0010);
        check_allow("R6 prog globally locked", 1'b1);
        pulse(0, 5, 1'b1);
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_read(12'h010, d); check("R5 glock all", d, 32'h15);
        check("R5 upper set", {31'b0, upper_lock}, 32'h1);
        bus_write(12'h010, 32'h0);
        bus_read(12'h010, d); check("R5 glock set-only", d, 32'h15);
        // R10 full fill: partial bank keeps only valid words
        for (int p = 0; p < 3; p++) begin
            bus_write(base_of(p), 32'hFFFF_FFFF);
            bus_write(base_of(p) + 12'd4, 32'hFFFF_FFFF);
            mdl[p] = '1;
        end
        check_planes("R10 partial bank");
        // R11 unmapped addresses
        bus_read(12'h000, d); check("R11 unmapped 000", d, 32'h0);
        bus_read(12'h018, d); check("R11 unmapped 018", d, 32'h0);
        bus_read(12'h0A0, d); check("R11 unmapped 0A0", d, 32'h0);
        bus_read(12'h065, d); check("R11 unaligned", d, 32'h0);
        // R1 reset clears everything again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int p = 0; p < 3; p++) mdl[p] = '0;
        check_planes("R1 re-reset planes");
        bus_read(12'h010, d); check("R1 re-reset glock", d, 32'h0);
        bus_read(12'h014, d); check("R1 re-reset dbg", d, 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule